// File: doc/BRIEF.md
# Multi-Rate Clock-Enable Strobe Generator

This block is the digital back end of a clock generator. Its input clock stands for an oscillator frequency multiplied by eight. A free-running 3-bit divider counter splits that clock into ratios of 1/1, 1/2, 1/4 and 1/8. Three outputs each pick one of these ratios independently: a system rate for the CPU and bus masters, a peripheral rate, and an external-bus rate. Each output is a one-cycle clock-enable strobe, not a gated clock, so every consumer stays on the base clock and qualifies its registers with its own strobe.

Software sets the ratios by writing one 9-bit control word. The block checks each write before it accepts it:

- A write that holds a reserved code is dropped.
- A write that would make the peripheral or external-bus rate faster than the system rate is rejected, and a sticky error flag is raised.

An accepted write is held as pending. It takes effect only when the divider counter wraps to zero, so no strobe period is ever cut short or stretched into an irregular one. The read port always shows the setting currently in effect.

Top module: `rate_strobe_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the read word is 0, the error flag is 0 and all three strobes are high. With the reset setting, every strobe is high in every cycle.
- R2: Field positions in the control word are: bits [2:0] system, bits [5:3] peripheral, bits [8:6] external bus. Field code k (0 to 3) divides by 2^k. The matching strobe is high exactly in the cycles where the low k bits of the divider counter are zero.
- R3: A field code of 4 to 7 (bit 2 of the field set) is reserved. A write carrying one in any field is ignored as a whole: the setting in effect, the pending setting and the error flag are all unchanged.
- R4: A write whose peripheral or bus code is smaller than its system code is rejected. The setting in effect and the pending setting are unchanged, and the error flag is set.
- R5: An accepted write becomes the setting in effect at the first clock edge where the counter steps from 7 to 0 after the write's own edge. A write sampled at that same edge waits for the next wrap.
- R6: `rd_data` returns the setting in effect, never a pending one.
- R7: Once set, the error flag stays high until reset.
- R8: When several accepted writes arrive before a wrap, only the last one is applied.
- R9: In any cycle where the system strobe is low, the peripheral and bus strobes are also low.
- R10: The divider counter is 0 in the first cycle after reset is released and advances by one every clock cycle. All three strobes are high whenever it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (oscillator times eight) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word: bus, peripheral and system codes |
| rd_data | output | 9 | Setting in effect, same layout as wr_data |
| err | output | 1 | Sticky flag for a rejected ordering write |
| sys_en | output | 1 | System rate clock-enable strobe |
| per_en | output | 1 | Peripheral rate clock-enable strobe |
| bus_en | output | 1 | External-bus rate clock-enable strobe |

## Verification
The bench writes every one of the 512 possible control words. Each write lands at a varying counter phase, so some writes hit the wrap edge itself and some follow one another within a single counter period. A design that applied a setting immediately would show `rd_data` changing and strobes shifting in the middle of a period. A design that forwarded pending values to the read port, or that kept the first of two quick writes instead of the last, would diverge from the bench model within a cycle. Writes that carry reserved codes, or that place the peripheral or bus rate above the system rate, expose any design that accepts them, that flags reserved codes as ordering errors, or that lets the error flag drop.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int FIELD_W   = 3;
    localparam int NUM_OUT   = 3;
    localparam int MAX_SHIFT = 3;
    localparam int CNT_W     = MAX_SHIFT;

    typedef logic [FIELD_W-1:0] code_t;

    typedef struct packed {
        code_t bus;
        code_t per;
        code_t sys;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/rsg_divcnt.sv
module rsg_divcnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign last_o = (st_q.cnt == {CNT_W{1'b1}});
endmodule

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
    import rsg_pkg::*;
#(
    parameter int MAX_CODE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    input  logic last_i,
    output cfg_t app_o,
    output logic err_o
);
    typedef struct packed {
        cfg_t app;
        cfg_t pend;
        logic pv;
        logic err;
    } st_t;

    st_t  st_d, st_q;
    logic reserved;
    logic misorder;

    always_comb begin
        reserved = (int'(wr_cfg.sys) > MAX_CODE) ||
                   (int'(wr_cfg.per) > MAX_CODE) ||
                   (int'(wr_cfg.bus) > MAX_CODE);
        misorder = (wr_cfg.per < wr_cfg.sys) || (wr_cfg.bus < wr_cfg.sys);

        st_d = st_q;
        // hand the pending word over only at the wrap edge
        if (last_i && st_q.pv) begin
            st_d.app = st_q.pend;
            st_d.pv  = 1'b0;
        end
        if (wr_en && !reserved) begin
            if (misorder) begin
                st_d.err = 1'b1;
            end else begin
                st_d.pend = wr_cfg;
                st_d.pv   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign app_o = st_q.app;
    assign err_o = st_q.err;
endmodule

// File: rtl/rsg_strobe.sv
module rsg_strobe
    import rsg_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  code_t            code_i,
    output logic             en_o
);
    always_comb begin
        en_o = 1'b1;
        for (int i = 0; i < CNT_W; i++) begin
            if ((i < int'(code_i)) && cnt_i[i]) en_o = 1'b0;
        end
    end
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
    import rsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             err,
    output logic             sys_en,
    output logic             per_en,
    output logic             bus_en
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;
    cfg_t             app;
    code_t            codes [NUM_OUT];
    logic [NUM_OUT-1:0] en_vec;

    rsg_divcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt_q),
        .last_o (last)
    );

    rsg_ctrl #(.MAX_CODE(MAX_SHIFT)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cfg (cfg_t'(wr_data)),
        .last_i (last),
        .app_o  (app),
        .err_o  (err)
    );

    assign codes[0] = app.sys;
    assign codes[1] = app.per;
    assign codes[2] = app.bus;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        rsg_strobe #(.CNT_W(CNT_W)) u_stb (
            .cnt_i  (cnt_q),
            .code_i (codes[g]),
            .en_o   (en_vec[g])
        );
    end

    assign sys_en  = en_vec[0];
    assign per_en  = en_vec[1];
    assign bus_en  = en_vec[2];
    assign rd_data = app;
endmodule

// File: rtl/rate_strobe_chk.sv
module rate_strobe_chk
    import rsg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CFG_W-1:0] rd_data,
    input logic             err,
    input logic             sys_en,
    input logic             per_en,
    input logic             bus_en
);
    cfg_t cur;
    assign cur = cfg_t'(rd_data);

    AST_APPLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (cnt == '0)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R7
    AST_PER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> sys_en); // R9
    AST_BUS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> sys_en); // R9
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur.sys) <= MAX_SHIFT) && (int'(cur.per) <= MAX_SHIFT) &&
        (int'(cur.bus) <= MAX_SHIFT)); // R3
    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.per >= cur.sys) && (cur.bus >= cur.sys)); // R4
    AST_ALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (sys_en && per_en && bus_en)); // R10
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.sys == '0) |-> sys_en); // R2
endmodule

bind rate_strobe_gen rate_strobe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .rd_data (rd_data),
    .err     (err),
    .sys_en  (sys_en),
    .per_en  (per_en),
    .bus_en  (bus_en)
);

// File: tb/sim_rate_strobe_gen.sv
`timescale 1ns/1ps
module sim_rate_strobe_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       err, sys_en, per_en, bus_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench reference state
    int       m_cnt;
    logic [8:0] m_app, m_pend;
    bit       m_pv, m_err;

    always #4 clk = ~clk;

    rate_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .err(err),
        .sys_en(sys_en), .per_en(per_en), .bus_en(bus_en)
    );

    function automatic bit exp_en(int cnt, logic [2:0] code);
        int period = 1 << int'(code);
        return (cnt % period) == 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_app <= '0; m_pend <= '0; m_pv <= 0; m_err <= 0;
        end else begin
            if (m_cnt == 7 && m_pv) begin
                m_app <= m_pend;
                m_pv  <= 0;
            end
            if (wr_en) begin
                if (wr_data[2] || wr_data[5] || wr_data[8]) begin
                    // reserved: dropped
                end else if (wr_data[5:3] < wr_data[2:0] ||
                             wr_data[8:6] < wr_data[2:0]) begin
                    m_err <= 1;
                end else begin
                    m_pend <= wr_data;
                    m_pv   <= 1;
                end
            end
            m_cnt <= (m_cnt + 1) % 8;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle_check();
        chk("R2 sys_en", int'(sys_en), int'(exp_en(m_cnt, m_app[2:0])));
        chk("R2 per_en", int'(per_en), int'(exp_en(m_cnt, m_app[5:3])));
        chk("R2 bus_en", int'(bus_en), int'(exp_en(m_cnt, m_app[8:6])));
        chk("R6 rd_data", int'(rd_data), int'(m_app));
        chk("R7 err", int'(err), int'(m_err));
        if (!sys_en) chk("R9 subset", int'(per_en | bus_en), 0);
        if (m_cnt == 0) chk("R10 all at zero", int'(sys_en & per_en & bus_en), 1);
    endtask

    task automatic step(); // one full cycle, sampled at the falling edge
        @(negedge clk);
        cycle_check();
    endtask

    task automatic do_write(logic [8:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        cycle_check();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", int'(rd_data), 0);
        chk("R1 err in reset", int'(err), 0);
        chk("R1 strobes in reset", int'({sys_en, per_en, bus_en}), 7);
        rst_n = 1'b1;
        #1;
        chk("R1 rd_data after release", int'(rd_data), 0);
        for (int i = 0; i < 16; i++) begin
            step();
            chk("R1 full rate", int'({sys_en, per_en, bus_en}), 7);
        end

        // R5: apply waits for wrap, R6: readback holds the old word
        while (m_cnt != 2) step();
        do_write(9'b011_010_001);
        chk("R6 pending hidden", int'(rd_data), 0);
        while (m_cnt != 0) step();
        chk("R5 applied at wrap", int'(rd_data), int'(9'b011_010_001));

        // R5: write on the wrap edge waits one more period
        while (m_cnt != 7) step();
        do_write(9'b001_001_000);
        chk("R5 same-edge write waits", int'(rd_data), int'(9'b011_010_001));
        for (int i = 0; i < 7; i++) step();
        chk("R5 still waiting", int'(rd_data), int'(9'b011_010_001));
        step();
        chk("R5 applied next wrap", int'(rd_data), int'(9'b001_001_000));

        // R8: last of two quick writes wins
        while (m_cnt != 1) step();
        do_write(9'b011_011_011);
        do_write(9'b010_011_001);
        while (m_cnt != 0) step();
        chk("R8 last write wins", int'(rd_data), int'(9'b010_011_001));

        // R3: reserved code ignored, no error
        while (m_cnt != 3) step();
        do_write(9'b000_100_000);
        while (m_cnt != 1) step();
        chk("R3 reserved ignored", int'(rd_data), int'(9'b010_011_001));
        chk("R3 no error", int'(err), 0);

        // R4: misordered write rejected and flagged
        do_write(9'b001_011_010);
        chk("R4 err set", int'(err), 1);
        while (m_cnt != 1) step();
        chk("R4 setting kept", int'(rd_data), int'(9'b010_011_001));

        // sweep of all 512 words at varying phases
        for (int w = 0; w < 512; w++) begin
            do_write(9'(w));
            for (int k = 0; k < (w % 11); k++) step();
        end
        for (int i = 0; i < 16; i++) step();

        // R7 / R1: error only clears on reset
        chk("R7 err still set", int'(err), 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 err cleared by reset", int'(err), 0);
        chk("R1 rd_data cleared", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule